// File: doc/BRIEF.md
# Radio-State-Driven GPIO Bank

This block is a two-sided general-purpose I/O bank for a transceiver daughterboard. One side serves the receive board, the other the transmit board, and each side has sixteen pins. Every pin is either an input or an output, set by a direction word. An output pin takes its value from one of four places: a software-written value, a pattern looked up from the current radio state, or one of two debug buses coming from the fabric.

The radio state comes from two status inputs, transmit-active and receive-active, which together give idle, transmit only, receive only or full duplex. A table of eight 16-bit patterns holds one word per state for each side. Pins in table mode therefore follow the radio without any software action. The pattern is registered, so the pins move one clock after the state changes. A small word-wide register port writes and reads all control words and table entries. Reading a side's value word returns that side's pad levels after a two-flop synchronizer.

Top module: `gpio_atr_bank`

## Requirements
- R1: After reset, all control words and table entries are zero. Every `*_pad_oe` and `*_pad_out` bit is 0, and every readable word other than the value words returns 0.
- R2: With `addr[4]`=0, `addr[3:1]` = {kind[1:0], side} selects a control word. Kinds are 0 value, 1 direction, 2 select and 3 debug. Side 0 is the receive side and side 1 the transmit side. `addr[0]` is ignored. A write with `wr_en` lands on the next rising edge. Direction, select and debug words read back what was written.
- R3: With `addr[4]`=1, `addr[3:1]` = {state[1:0], side} selects a table entry, and every entry reads back what was written.
- R4: A side's `*_pad_oe` equals its direction word. A pin whose direction bit is 0 has its `*_pad_out` bit held at 0.
- R5: An output pin with debug bit 0 and select bit 0 drives the side's value word.
- R6: An output pin with debug bit 0 and select bit 1 drives the table entry for the current state. The state is {rx_active, tx_active}: 00 idle, 01 transmit, 10 receive, 11 full duplex.
- R7: The table pattern is registered. After the state inputs change, pins in table mode keep the old pattern until the next rising edge and show the new one after it.
- R8: An output pin with debug bit 1 drives debug bus 0 when its select bit is 0 and debug bus 1 when its select bit is 1.
- R9: Reading a side's value word returns its pad inputs delayed by two rising edges. The written software value never appears in that readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 5 | Byte address of the register port |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr`, combinational |
| tx_active | input | 1 | Radio is transmitting |
| rx_active | input | 1 | Radio is receiving |
| rx_dbg0 | input | 16 | Receive-side debug bus 0 |
| rx_dbg1 | input | 16 | Receive-side debug bus 1 |
| tx_dbg0 | input | 16 | Transmit-side debug bus 0 |
| tx_dbg1 | input | 16 | Transmit-side debug bus 1 |
| rx_pad_in | input | 16 | Receive-side pad levels |
| tx_pad_in | input | 16 | Transmit-side pad levels |
| rx_pad_out | output | 16 | Receive-side pad drive values |
| rx_pad_oe | output | 16 | Receive-side pad output enables |
| tx_pad_out | output | 16 | Transmit-side pad drive values |
| tx_pad_oe | output | 16 | Transmit-side pad output enables |

## Verification
The bench drives mixed words in which select, debug and direction bits differ pin by pin within one word. A mux decoded per word instead of per pin, or with the select polarity swapped, then gives wrong bits in a few positions. All four radio states are visited with a distinct pattern per state and side. A swapped {rx, tx} index or a crossed side therefore shows up as a wrong pattern. The bench samples the pins just before and just after the edge that follows a state change, which catches a table path that is not registered or has an extra stage. The pad readback is sampled after one edge and after two, so a synchronizer of the wrong depth, or a readback that returns the written value, is caught.

// File: rtl/gpio_atr_pkg.sv
package gpio_atr_pkg;

  // Index width of the register file (8 words per bank)
  localparam int IDX_W  = 3;
  // Byte address: bank bit, index, ignored byte bit
  localparam int ADDR_W = IDX_W + 2;
  localparam int NSIDE  = 2;
  localparam int NWORD  = 1 << IDX_W;

  typedef enum logic [1:0] {
    KIND_VALUE = 2'd0,
    KIND_DIR   = 2'd1,
    KIND_SEL   = 2'd2,
    KIND_DEBUG = 2'd3
  } ctl_kind_e;

  typedef enum logic [1:0] {
    RADIO_IDLE = 2'b00,
    RADIO_TX   = 2'b01,
    RADIO_RX   = 2'b10,
    RADIO_FULL = 2'b11
  } radio_state_e;

  function automatic logic [1:0] radio_state(input logic rx, input logic tx);
    return {rx, tx};
  endfunction

  function automatic logic [IDX_W-1:0] ctl_slot(input ctl_kind_e kind, input logic side);
    return {kind, side};
  endfunction

  function automatic logic [IDX_W-1:0] table_slot(input logic [1:0] st, input logic side);
    return {st, side};
  endfunction

endpackage

// File: rtl/gpio_atr_regs.sv
module gpio_atr_regs
  import gpio_atr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [W-1:0]                wr_data,
  input  logic [NSIDE-1:0][W-1:0]     pad_sync,
  output logic [W-1:0]                rd_data,
  output logic [NWORD-1:0][W-1:0]     ctl_words,
  output logic [NWORD-1:0][W-1:0]     table_words
);

  logic             bank_table;
  logic [IDX_W-1:0] slot;
  logic             unused_byte_bit;

  assign bank_table      = addr[ADDR_W-1];
  assign slot            = addr[IDX_W:1];
  assign unused_byte_bit = addr[0];

  // Named write strobes, one per stored word
  logic [NWORD-1:0] ctl_we;
  logic [NWORD-1:0] table_we;

  logic [W-1:0] ctl_q   [NWORD];
  logic [W-1:0] table_q [NWORD];

  for (genvar i = 0; i < NWORD; i++) begin : g_word
    assign ctl_we[i]   = wr_en && !bank_table && (slot == IDX_W'(i));
    assign table_we[i] = wr_en &&  bank_table && (slot == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ctl_q[i] <= '0;
      else if (ctl_we[i])  ctl_q[i] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            table_q[i] <= '0;
      else if (table_we[i])  table_q[i] <= wr_data;
    end

    assign ctl_words[i]   = ctl_q[i];
    assign table_words[i] = table_q[i];

    // R2
    ctl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we[i] |=> (ctl_q[i] == $past(wr_data)));

    // R3
    table_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      table_we[i] |=> (table_q[i] == $past(wr_data)));
  end

  always_comb begin
    if (bank_table)
      rd_data = table_q[slot];
    else if (ctl_kind_e'(slot[IDX_W-1:1]) == KIND_VALUE)
      rd_data = pad_sync[slot[0]];
    else
      rd_data = ctl_q[slot];
  end

endmodule

// File: rtl/gpio_atr_pick.sv
module gpio_atr_pick
  import gpio_atr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rx_active,
  input  logic                     tx_active,
  input  logic [NWORD-1:0][W-1:0]  table_words,
  output logic [NSIDE-1:0][W-1:0]  pattern
);

  logic [1:0] state_now;
  assign state_now = radio_state(rx_active, tx_active);

  logic [W-1:0] pattern_q [NSIDE];

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pattern_q[s] <= '0;
      else        pattern_q[s] <= table_words[table_slot(state_now, 1'(s))];
    end
    assign pattern[s] = pattern_q[s];
  end

  // R7
  pattern_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(state_now) && $stable(table_words)) |=> $stable(pattern));

endmodule

// File: rtl/gpio_pin_side.sv
module gpio_pin_side #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sw_value,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] sel,
  input  logic [W-1:0] dbg,
  input  logic [W-1:0] pattern,
  input  logic [W-1:0] dbg_bus0,
  input  logic [W-1:0] dbg_bus1,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_sync
);

  // Per-pin source choice, then gating by direction
  function automatic logic [W-1:0] drive_word(
    input logic [W-1:0] sw, input logic [W-1:0] pat,
    input logic [W-1:0] d0, input logic [W-1:0] d1,
    input logic [W-1:0] s,  input logic [W-1:0] dm,
    input logic [W-1:0] oe);
    logic [W-1:0] normal_src;
    logic [W-1:0] debug_src;
    normal_src = (s & pat) | (~s & sw);
    debug_src  = (s & d1)  | (~s & d0);
    return oe & ((dm & debug_src) | (~dm & normal_src));
  endfunction

  assign pad_oe  = dir;
  assign pad_out = drive_word(sw_value, pattern, dbg_bus0, dbg_bus1, sel, dbg, dir);

  logic [W-1:0] sync_a;
  logic [W-1:0] sync_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
    end else begin
      sync_a <= pad_in;
      sync_b <= sync_a;
    end
  end

  assign pad_sync = sync_b;

  // Edges since reset, saturating, so the check never looks before reset
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm <= '0;
    else if (warm != 2'd3)   warm <= warm + 2'd1;
  end

  // R9
  sync_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> (pad_sync == $past(pad_in, 2)));

endmodule

// File: rtl/gpio_atr_bank.sv
module gpio_atr_bank
  import gpio_atr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      rd_data,
  input  logic              tx_active,
  input  logic              rx_active,
  input  logic [W-1:0]      rx_dbg0,
  input  logic [W-1:0]      rx_dbg1,
  input  logic [W-1:0]      tx_dbg0,
  input  logic [W-1:0]      tx_dbg1,
  input  logic [W-1:0]      rx_pad_in,
  input  logic [W-1:0]      tx_pad_in,
  output logic [W-1:0]      rx_pad_out,
  output logic [W-1:0]      rx_pad_oe,
  output logic [W-1:0]      tx_pad_out,
  output logic [W-1:0]      tx_pad_oe
);

  logic [NWORD-1:0][W-1:0] ctl_words;
  logic [NWORD-1:0][W-1:0] table_words;
  logic [NSIDE-1:0][W-1:0] pattern;
  logic [NSIDE-1:0][W-1:0] pad_sync;
  logic [NSIDE-1:0][W-1:0] pads_in;
  logic [NSIDE-1:0][W-1:0] bus0;
  logic [NSIDE-1:0][W-1:0] bus1;
  logic [NSIDE-1:0][W-1:0] pads_out;
  logic [NSIDE-1:0][W-1:0] pads_oe;

  assign pads_in = {tx_pad_in, rx_pad_in};
  assign bus0    = {tx_dbg0, rx_dbg0};
  assign bus1    = {tx_dbg1, rx_dbg1};

  gpio_atr_regs #(.W(W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .addr        (addr),
    .wr_data     (wr_data),
    .pad_sync    (pad_sync),
    .rd_data     (rd_data),
    .ctl_words   (ctl_words),
    .table_words (table_words)
  );

  gpio_atr_pick #(.W(W)) u_pick (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_active   (rx_active),
    .tx_active   (tx_active),
    .table_words (table_words),
    .pattern     (pattern)
  );

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    gpio_pin_side #(.W(W)) u_side (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_value (ctl_words[ctl_slot(KIND_VALUE, 1'(s))]),
      .dir      (ctl_words[ctl_slot(KIND_DIR,   1'(s))]),
      .sel      (ctl_words[ctl_slot(KIND_SEL,   1'(s))]),
      .dbg      (ctl_words[ctl_slot(KIND_DEBUG, 1'(s))]),
      .pattern  (pattern[s]),
      .dbg_bus0 (bus0[s]),
      .dbg_bus1 (bus1[s]),
      .pad_in   (pads_in[s]),
      .pad_out  (pads_out[s]),
      .pad_oe   (pads_oe[s]),
      .pad_sync (pad_sync[s])
    );
  end

  assign rx_pad_out = pads_out[0];
  assign rx_pad_oe  = pads_oe[0];
  assign tx_pad_out = pads_out[1];
  assign tx_pad_oe  = pads_oe[1];

endmodule

// File: tb/gpio_atr_bank_test.sv
module gpio_atr_bank_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        tx_active = 1'b0;
  logic        rx_active = 1'b0;
  logic [15:0] rx_dbg0 = 16'h6996;
  logic [15:0] rx_dbg1 = 16'h9669;
  logic [15:0] tx_dbg0 = 16'hAAAA;
  logic [15:0] tx_dbg1 = 16'h5555;
  logic [15:0] rx_pad_in = '0;
  logic [15:0] tx_pad_in = '0;
  logic [15:0] rx_pad_out, rx_pad_oe, tx_pad_out, tx_pad_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_atr_bank uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .tx_active(tx_active), .rx_active(rx_active),
    .rx_dbg0(rx_dbg0), .rx_dbg1(rx_dbg1), .tx_dbg0(tx_dbg0), .tx_dbg1(tx_dbg1),
    .rx_pad_in(rx_pad_in), .tx_pad_in(tx_pad_in),
    .rx_pad_out(rx_pad_out), .rx_pad_oe(rx_pad_oe),
    .tx_pad_out(tx_pad_out), .tx_pad_oe(tx_pad_oe)
  );

  // Table entries, listed [state*2 + side]
  localparam logic [15:0] PAT [0:7] = '{
    16'h0F0F, 16'hF00F, 16'h3C3C, 16'h1248,
    16'h5A5A, 16'h8421, 16'hC3C3, 16'h7E7E };

  // Row: {state, dir, sel, dbg, sw}; transmit side gets ~sw
  localparam logic [65:0] VEC [0:7] = '{
    {2'd0, 16'hFFFF, 16'h0000, 16'h0000, 16'h1234},
    {2'd1, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000},
    {2'd2, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000},
    {2'd3, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000},
    {2'd1, 16'hFF00, 16'hF0F0, 16'h0000, 16'hBEEF},
    {2'd2, 16'hFFFF, 16'h00FF, 16'hFFFF, 16'h0000},
    {2'd3, 16'h0F0F, 16'h3333, 16'h5555, 16'hC0DE},
    {2'd0, 16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF} };

  function automatic logic [4:0] ctl_addr(input int kind, input int side);
    return {1'b0, 2'(kind), 1'(side), 1'b0};
  endfunction

  function automatic logic [4:0] tab_addr(input int st, input int side);
    return {1'b1, 2'(st), 1'(side), 1'b0};
  endfunction

  function automatic logic [15:0] model_out(input int side, input logic [1:0] st,
      input logic [15:0] dir, input logic [15:0] sel, input logic [15:0] dbg,
      input logic [15:0] sw);
    logic [15:0] r;
    logic [15:0] d0, d1;
    d0 = side ? 16'hAAAA : 16'h6996;
    d1 = side ? 16'h5555 : 16'h9669;
    for (int b = 0; b < 16; b++) begin
      if (!dir[b])      r[b] = 1'b0;
      else if (dbg[b])  r[b] = sel[b] ? d1[b] : d0[b];
      else if (sel[b])  r[b] = PAT[st*2 + side][b];
      else              r[b] = sw[b];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [4:0] a, input logic [15:0] exp);
    addr = a;
    #1;
    check(tag, rd_data, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 32; a += 2) rd_check("R1 reset readback", 5'(a), 16'h0000);
    check("R1 rx oe", rx_pad_oe, 16'h0000);
    check("R1 tx oe", tx_pad_oe, 16'h0000);
    check("R1 rx out", rx_pad_out, 16'h0000);
    check("R1 tx out", tx_pad_out, 16'h0000);

    // R3: fill and read back the table
    for (int i = 0; i < 8; i++) wr(tab_addr(i / 2, i % 2), PAT[i]);
    for (int i = 0; i < 8; i++) rd_check("R3 table readback", tab_addr(i / 2, i % 2), PAT[i]);

    // R2: control words readback, byte bit ignored
    wr(ctl_addr(1, 0) | 5'd1, 16'h1357);
    rd_check("R2 rx dir", ctl_addr(1, 0) | 5'd1, 16'h1357);
    wr(ctl_addr(2, 1), 16'h2468);
    rd_check("R2 tx sel", ctl_addr(2, 1), 16'h2468);
    wr(ctl_addr(3, 0), 16'h0F1E);
    rd_check("R2 rx debug", ctl_addr(3, 0), 16'h0F1E);
    rd_check("R2 tx dir untouched", ctl_addr(1, 1), 16'h0000);

    // R4 R5 R6 R8: vector table
    for (int v = 0; v < 8; v++) begin
      logic [1:0]  st;
      logic [15:0] dir, sel, dbg, sw;
      {st, dir, sel, dbg, sw} = VEC[v];
      wr(ctl_addr(0, 0), sw);
      wr(ctl_addr(0, 1), ~sw);
      for (int s = 0; s < 2; s++) begin
        wr(ctl_addr(1, s), dir);
        wr(ctl_addr(2, s), sel);
        wr(ctl_addr(3, s), dbg);
      end
      rx_active = st[1];
      tx_active = st[0];
      @(negedge clk);
      @(negedge clk);
      check("R4 rx oe", rx_pad_oe, dir);
      check("R4 tx oe", tx_pad_oe, dir);
      check("R5 R6 R8 rx out", rx_pad_out, model_out(0, st, dir, sel, dbg, sw));
      check("R5 R6 R8 tx out", tx_pad_out, model_out(1, st, dir, sel, dbg, ~sw));
    end

    // R7: table mode, registered pattern
    for (int s = 0; s < 2; s++) begin
      wr(ctl_addr(1, s), 16'hFFFF);
      wr(ctl_addr(2, s), 16'hFFFF);
      wr(ctl_addr(3, s), 16'h0000);
    end
    rx_active = 1'b0; tx_active = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R7 settled transmit", rx_pad_out, PAT[2]);
    rx_active = 1'b1; tx_active = 1'b0;
    #1;
    check("R7 before edge rx", rx_pad_out, PAT[2]);
    check("R7 before edge tx", tx_pad_out, PAT[3]);
    @(negedge clk);
    check("R7 after edge rx", rx_pad_out, PAT[4]);
    check("R7 after edge tx", tx_pad_out, PAT[5]);
    rx_active = 1'b1; tx_active = 1'b1;
    @(negedge clk);
    check("R7 full duplex", tx_pad_out, PAT[7]);

    // R9: synchronised readback of pad levels
    wr(ctl_addr(0, 0), 16'hFFFF);
    wr(ctl_addr(0, 1), 16'h0000);
    @(negedge clk);
    rd_check("R9 rx idle level", ctl_addr(0, 0), 16'h0000);
    rx_pad_in = 16'hC001;
    tx_pad_in = 16'h7F80;
    #1;
    rd_check("R9 rx no edge", ctl_addr(0, 0), 16'h0000);
    @(negedge clk);
    rd_check("R9 rx one edge", ctl_addr(0, 0), 16'h0000);
    @(negedge clk);
    rd_check("R9 rx two edges", ctl_addr(0, 0), 16'hC001);
    rd_check("R9 tx two edges", ctl_addr(0, 1), 16'h7F80);

    finish_run();
  end

endmodule